// File: doc/BRIEF.md
# Direct-Mapped Write-Through Line Cache

This block sits between a 32-bit processor load/store port and a main memory port that moves one 32-bit word at a time. It holds a direct-mapped array of lines. Each line has four 32-bit words, one tag and one valid flag. Every byte address is split into four fields, from high bits to low: tag, line index, word offset and byte offset. A lookup checks the valid flag and the stored tag of the indexed line. On a hit, the word offset picks one of the four words of the line.

On any miss, the processor is held by `cpu_stall`. The controller then reloads the whole line with four single-word memory reads, validates the line and replays the access, which now hits. Stores use write-through. The cache copy is updated and the same word is written to memory, and the processor stays stalled until memory accepts the write. A store that misses first reloads the line and then merges the new word into it.

The processor keeps its request, address and write data stable while `cpu_stall` is high. An access finishes in the cycle in which `cpu_req` is high and `cpu_stall` is low.

Top module: `dm_line_cache`

## Requirements
- R1: Address fields are tag = `cpu_addr[31:IDX_W+4]`, line index = `cpu_addr[IDX_W+3:4]`, word offset = `cpu_addr[3:2]`. Byte offset `cpu_addr[1:0]` has no effect on the result.
- R2: After reset no line is valid, so the first access to every line is a miss that reloads it from memory.
- R3: A read whose indexed line is valid with a matching tag completes in its request cycle (`cpu_stall` low) and issues no memory request.
- R4: On a read hit, `cpu_rdata` is the word of the line selected by the word offset: 0 picks the word at line base +0, and 3 picks the word at +12.
- R5: A miss reloads the line with exactly four memory reads (`mem_we` low) at the line base address plus word offsets 0, 1, 2, 3, in that order. Each read waits for `mem_ack`. The replayed access then returns the memory contents.
- R6: The line's tag and valid flag are written only when the fourth refill word is accepted. Until then the line does not report a hit.
- R7: A store hit updates the cached word and writes the same word to `mem_addr` = `{cpu_addr[31:2],2'b00}` with `mem_we` high. `cpu_stall` stays high until the cycle `mem_ack` returns.
- R8: A store miss reloads the line first, then merges the stored word into it and writes it through. The other three words of the line keep their memory values.
- R9: Two addresses with the same index and different tags share one line, so each one evicts the other.
- R10: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until it is acknowledged. With memory acknowledging one cycle after each request, latency is 1 cycle for a read hit, 3 for a store hit, 11 for a read miss and 13 for a store miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the access completes |
| cpu_stall | output | 1 | High while the access cannot complete |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge, one cycle per word |

## Verification
The assertions check the cycle-level rules on every cycle:
- a memory request holds still until it is acknowledged;
- a line never reports a hit while it is being refilled;
- a load hit never touches memory;
- every memory write carries the processor's word and address;
- every refill read stays within the requested line.

Only the bench's scenarios can show the rest, by comparing returned words with a reference copy of memory. That covers the correctness of the data, the beat order, latencies, eviction between conflicting tags, and the fact that write-through reaches memory.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned WORDS  = 4;
  localparam int unsigned OFF_W  = $clog2(WORDS);
  localparam int unsigned BYTE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REFILL = 2'd1,
    ST_WRMEM  = 2'd2,
    ST_RETRY  = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/dmc_rst_sync.sv
module dmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             wr_en,
  output logic             hit
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // Valid flags are the only reset state; tags need none.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx] <= tag;
    end
  end

  assign hit = valid_q[idx] && (tag_q[idx] == tag);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
  import dmc_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [WORDS-1:0][WORD_W-1:0] word_rd;

  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] bank_q [LINES];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == OFF_W'(w))) begin
        bank_q[idx] <= wr_data;
      end
    end
    assign word_rd[w] = bank_q[idx];
  end

  // Word multiplexer steered by the word offset.
  assign rd_data = word_rd[rd_sel];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic             hit,
  input  logic             mem_ack,
  output ctl_state_t       state,
  output logic [OFF_W-1:0] beat,
  output logic             cpu_stall,
  output logic             mem_req,
  output logic             mem_we,
  output logic             fill_we,
  output logic             line_set,
  output logic             word_we
);
  ctl_state_t       state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic             beat_en;
  logic             last_beat;

  assign last_beat = (beat_q == OFF_W'(WORDS - 1));

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    beat_en   = 1'b0;
    cpu_stall = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    fill_we   = 1'b0;
    line_set  = 1'b0;
    word_we   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          cpu_stall = !hit || cpu_we;
          if (!hit) begin
            state_d = ST_REFILL;
            beat_d  = '0;
            beat_en = 1'b1;
          end else if (cpu_we) begin
            word_we = 1'b1;
            state_d = ST_WRMEM;
          end
        end
      end
      ST_REFILL: begin
        cpu_stall = 1'b1;
        mem_req   = 1'b1;
        if (mem_ack) begin
          fill_we = 1'b1;
          beat_d  = beat_q + 1'b1;
          beat_en = 1'b1;
          if (last_beat) begin
            line_set = 1'b1;
            state_d  = ST_RETRY;
          end
        end
      end
      ST_RETRY: begin
        cpu_stall = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_WRMEM: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        cpu_stall = !mem_ack;
        if (mem_ack) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) begin
        beat_q <= beat_d;
      end
    end
  end

  assign state = state_q;
  assign beat  = beat_q;

  // R10: an outstanding memory request holds still until acknowledged
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && (mem_we == $past(mem_we)) && (beat == $past(beat))));
endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache
  import dmc_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int unsigned LOW_W = OFF_W + BYTE_W;
  localparam int unsigned TAG_W = ADDR_W - IDX_W - LOW_W;

  logic                rst_sync_n;
  logic [TAG_W-1:0]    addr_tag;
  logic [IDX_W-1:0]    addr_idx;
  logic [OFF_W-1:0]    addr_off;
  logic [BYTE_W-1:0]   unused_byte_bits;
  logic                hit;
  ctl_state_t          state;
  logic [OFF_W-1:0]    beat;
  logic                fill_we;
  logic                line_set;
  logic                word_we;
  logic                dwr_en;
  logic [OFF_W-1:0]    dwr_sel;
  logic [WORD_W-1:0]   dwr_data;

  assign addr_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
  assign addr_idx         = cpu_addr[LOW_W +: IDX_W];
  assign addr_off         = cpu_addr[BYTE_W +: OFF_W];
  assign unused_byte_bits = cpu_addr[BYTE_W-1:0];

  dmc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .idx   (addr_idx),
    .tag   (addr_tag),
    .wr_en (line_set),
    .hit   (hit)
  );

  dmc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .hit       (hit),
    .mem_ack   (mem_ack),
    .state     (state),
    .beat      (beat),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .fill_we   (fill_we),
    .line_set  (line_set),
    .word_we   (word_we)
  );

  // Single write port: refill beats take the memory word, stores the CPU word.
  always_comb begin
    dwr_en   = fill_we || word_we;
    dwr_sel  = fill_we ? beat : addr_off;
    dwr_data = fill_we ? mem_rdata : cpu_wdata;
  end

  dmc_data_store #(.IDX_W(IDX_W)) u_data (
    .clk     (clk),
    .idx     (addr_idx),
    .wr_en   (dwr_en),
    .wr_sel  (dwr_sel),
    .wr_data (dwr_data),
    .rd_sel  (addr_off),
    .rd_data (cpu_rdata)
  );

  assign mem_addr  = mem_we ? {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}
                            : {cpu_addr[ADDR_W-1:LOW_W], beat, {BYTE_W{1'b0}}};
  assign mem_wdata = cpu_wdata;

  // R6: the line being refilled never reports a hit before validation
  a_r6_no_hit_mid_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_REFILL) |-> !hit);

  // R3: a load hit in idle completes at once without touching memory
  a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_IDLE && cpu_req && !cpu_we && hit) |-> (!cpu_stall && !mem_req));

  // R7: every memory write carries the processor's word and word address
  a_r7_write_through: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && mem_we) |-> ((mem_addr[31:2] == cpu_addr[31:2]) && (mem_wdata == cpu_wdata)));

  // R5: refill reads stay inside the requested line
  a_r5_fill_in_line: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_we) |-> (mem_addr[31:4] == cpu_addr[31:4] && mem_addr[1:0] == 2'b00));
endmodule

// File: tb/dm_line_cache_tb.sv
module dm_line_cache_tb;
  localparam int IDX_W = 4;

  logic        clk;
  logic        rst_n;
  logic        cpu_req;
  logic        cpu_we;
  logic [31:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  int n_checks = 0;
  int n_fail   = 0;
  int n_rd     = 0;
  int n_wr     = 0;
  int order_err = 0;
  logic [1:0] exp_beat = 2'd0;

  logic [31:0] mem_arr [4096];
  logic [31:0] shadow  [4096];

  dm_line_cache #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] init_word(int i);
    return 32'h5A00_0000 + i * 32'h0001_0203;
  endfunction

  // Memory model: acknowledges one cycle after each request
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem_arr[mem_addr[13:2]] <= mem_wdata;
        n_wr <= n_wr + 1;
      end else begin
        mem_rdata <= mem_arr[mem_addr[13:2]];
        n_rd <= n_rd + 1;
        if (mem_addr[3:2] != exp_beat) order_err <= order_err + 1;
        exp_beat <= exp_beat + 2'd1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
    logic done;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    done = 1'b0;
    while (!done) begin
      #2;
      done = !cpu_stall;
      rd = cpu_rdata;
      cyc++;
      @(negedge clk);
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (we) shadow[a[13:2]] = d;
  endtask

  task automatic rd_chk(input logic [31:0] a, input int exp_cyc, input int exp_reads, input string tag);
    logic [31:0] rd;
    int cyc;
    int r0;
    r0 = n_rd;
    access(1'b0, a, 32'h0, rd, cyc);
    check(rd == shadow[a[13:2]], {tag, " data"}, rd, shadow[a[13:2]]);
    check(cyc == exp_cyc, {tag, " latency"}, cyc, exp_cyc);
    check((n_rd - r0) == exp_reads, {tag, " memory reads"}, n_rd - r0, exp_reads);
  endtask

  initial begin
    logic [31:0] rd;
    int cyc, r0, w0;
    for (int i = 0; i < 4096; i++) begin
      mem_arr[i] = init_word(i);
      shadow[i]  = init_word(i);
    end
    mem_ack = 1'b0; mem_rdata = '0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(!cpu_stall, "R2 reset stall low", {31'b0, cpu_stall}, 32'h0);
    check(!mem_req, "R2 reset no memory request", {31'b0, mem_req}, 32'h0);

    rd_chk(32'h0000_0100, 11, 4, "R2 R5 R10 first read miss");
    rd_chk(32'h0000_0100, 1, 0, "R3 R6 read hit after refill");
    for (int off = 0; off < 4; off++)
      for (int b = 0; b < 4; b++)
        rd_chk(32'h0000_0100 + off * 4 + b, 1, 0, "R1 R4 word and byte offset sweep");

    for (int i = 0; i < 16; i++)
      rd_chk(32'h0000_1000 + i * 16 + (i % 4) * 4, 11, 4, "R2 per-line first miss");
    for (int i = 0; i < 16; i++)
      for (int off = 0; off < 4; off++)
        rd_chk(32'h0000_1000 + i * 16 + off * 4, 1, 0, "R3 R4 per-line hit");

    rd_chk(32'h0000_1520, 11, 4, "R9 conflicting tag misses");
    rd_chk(32'h0000_1020, 11, 4, "R9 evicted tag misses again");
    rd_chk(32'h0000_1520, 11, 4, "R9 evicted the other way");
    rd_chk(32'h0000_1024, 11, 4, "R9 original tag reloaded");

    r0 = n_rd; w0 = n_wr;
    access(1'b1, 32'h0000_1024, 32'hDEAD_0001, rd, cyc);
    check(cyc == 3, "R7 R10 store hit latency", cyc, 3);
    check((n_wr - w0) == 1, "R7 one memory write", n_wr - w0, 1);
    check((n_rd - r0) == 0, "R7 no memory read", n_rd - r0, 0);
    check(mem_arr[12'h409] == 32'hDEAD_0001, "R7 memory holds stored word", mem_arr[12'h409], 32'hDEAD_0001);
    rd_chk(32'h0000_1024, 1, 0, "R7 cached word updated");

    r0 = n_rd; w0 = n_wr;
    access(1'b1, 32'h0000_2038, 32'hBEEF_0002, rd, cyc);
    check(cyc == 13, "R8 R10 store miss latency", cyc, 13);
    check((n_rd - r0) == 4, "R8 line refilled", n_rd - r0, 4);
    check((n_wr - w0) == 1, "R8 write through", n_wr - w0, 1);
    for (int off = 0; off < 4; off++)
      rd_chk(32'h0000_2030 + off * 4, 1, 0, "R8 merged line contents");
    rd_chk(32'h0000_2138, 11, 4, "R8 R9 evict stored line");
    rd_chk(32'h0000_2038, 11, 4, "R7 R8 memory kept stored word");

    check(order_err == 0, "R5 refill beat order", order_err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule